// File: doc/BRIEF.md
# Burst Target on a Shared Address/Data Bus

This block is a synchronous slave on a shared 32-bit bus that carries an address and then data on the same wires. A transaction opens when the initiator pulls the frame strobe low. On that clock the target latches the address and the 4-bit command. It claims the transaction if the address falls inside its memory window, or if the configuration select input is high and the command is a configuration access. It then moves data between the bus and a small internal register file, one dword per data phase, until the initiator signals the last phase.

The low-active control outputs (device select, target ready) and the data bus are modelled as a value port paired with a drive-enable port. An enable of 0 means the line is released. Arbitration, locking, early termination by the target, parity and electrical behaviour are not modelled.

Top module: `bus_burst_target`

## Requirements
- R1: While `rst_n` is low, and asynchronously as soon as it falls, `ad_oe`, `trdy_oe` and `devsel_oe` are 0, `trdy_n` and `devsel_n` read 1, `ad_out` reads 0, and the register file is cleared to zero.
- R2: The address phase is the first clock edge, from idle, at which `frame_n` is sampled low. On that edge the target latches `ad_in` as the address and `cbe_n` as the command. Memory read is 4'b0110 and memory write is 4'b0111. A memory access is claimed when `ad_in[31:AW+2]` equals `BASE_ADDR[31:AW+2]`, and the starting dword index is `ad_in[AW+1:2]`, where AW is log2(DEPTH).
- R3: Configuration read (4'b1010) and configuration write (4'b1011) are claimed only when `cfg_sel` is high in the address phase, whatever the address. They use the same dword index bits and the same register file. With `cfg_sel` low they are not claimed.
- R4: An unclaimed access drives no output for its whole duration and leaves the register file unchanged.
- R5: `devsel_oe` is 1 with `devsel_n` at 0 from the clock after the address phase until the final data phase completes. `trdy_n` is never 0 unless device select is active.
- R6: On writes, target ready is active in the first clock after the address phase. On reads, exactly one wait state comes first, so target ready first goes active in the second clock after the address phase.
- R7: A data phase completes only at an edge where `irdy_n` and `trdy_n` are both sampled 0. While `irdy_n` is 1, target ready stays active and `ad_out` stays unchanged.
- R8: On a completed write phase, bit b of `cbe_n` at 0 writes byte b (`ad_in[8b+7:8b]`, bit 0 being the least significant byte) into the addressed dword. A byte whose enable is 1 keeps its old value.
- R9: The dword index advances by one after each completed data phase and wraps modulo DEPTH.
- R10: A phase that completes with `frame_n` sampled 1 is the last one. On the following clock all outputs are released.
- R11: On reads, `ad_out` carries the addressed dword and `ad_oe` is 1 exactly while target ready is active. On writes, `ad_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Frame strobe from the initiator, low active |
| irdy_n | input | 1 | Initiator ready, low active |
| cfg_sel | input | 1 | Chip select for configuration accesses |
| ad_in | input | 32 | Address/data bus as seen by the target |
| cbe_n | input | 4 | Command in the address phase, low-active byte enables in data phases |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| trdy_n | output | 1 | Target ready value, low active |
| trdy_oe | output | 1 | Drive enable for `trdy_n` |
| devsel_n | output | 1 | Device select value, low active |
| devsel_oe | output | 1 | Drive enable for `devsel_n` |

## Verification
The bench stretches phases with initiator waits on both reads and writes. A target that completed phases on its own ready alone would skip or repeat dwords, and the read-back would show it. It writes partial byte masks over known data, which catches reversed or inverted enables, and it runs a burst off the top of the file to expose index wrapping that is missing or misplaced. It also checks that an out-of-window write, and a configuration write without the select, neither claim the bus nor alter the stored data. It measures the first-ready latency separately for reads and writes, and it pulls reset in the middle of a burst to confirm that every driver is released at once.

// File: rtl/bus_burst_target.sv
module bus_burst_target #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
  parameter int          DEPTH     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        cfg_sel,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n,
  output logic        trdy_oe,
  output logic        devsel_n,
  output logic        devsel_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;
  localparam logic [3:0] CMD_CRD = 4'b1010;
  localparam logic [3:0] CMD_CWR = 4'b1011;

  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_WAIT, ST_XFER} st_t;

  st_t            st;
  logic [AW-1:0]  idx;
  logic           wr;
  logic [31:0]    rf [DEPTH];

  wire is_mem = (cbe_n == CMD_MRD) || (cbe_n == CMD_MWR);
  wire is_cfg = cfg_sel && ((cbe_n == CMD_CRD) || (cbe_n == CMD_CWR));
  wire in_win = ad_in[31:AW+2] == BASE_ADDR[31:AW+2];
  wire claim  = (is_mem && in_win) || is_cfg;
  wire beat   = (st == ST_XFER) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
      wr  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (!frame_n) begin
          idx <= ad_in[AW+1:2];
          wr  <= cbe_n[0];
          if (!claim)        st <= ST_SKIP;
          else if (cbe_n[0]) st <= ST_XFER;
          else               st <= ST_WAIT;
        end
        ST_SKIP: if (frame_n && irdy_n) st <= ST_IDLE;
        ST_WAIT: st <= ST_XFER;
        ST_XFER: if (beat) begin
          idx <= idx + 1'b1;
          if (frame_n) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rf[i] <= '0;
    end else if (beat && wr) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) rf[idx][8*b +: 8] <= ad_in[8*b +: 8];
    end
  end

  assign devsel_oe = (st == ST_WAIT) || (st == ST_XFER);
  assign devsel_n  = !devsel_oe;
  assign trdy_oe   = devsel_oe;
  assign trdy_n    = !(st == ST_XFER);
  assign ad_oe     = (st == ST_XFER) && !wr;
  assign ad_out    = ad_oe ? rf[idx] : '0;
endmodule

module bus_burst_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        trdy_n,
  input logic        trdy_oe,
  input logic        devsel_n,
  input logic        devsel_oe
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!ad_oe && !trdy_oe && !devsel_oe));

  a_r5_ready_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (devsel_oe && !devsel_n));

  a_r5_claim_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_oe) |-> !$past(frame_n));

  a_r6_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_oe && trdy_n) |=> !trdy_n);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

  a_r10_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (!devsel_oe && !trdy_oe && !ad_oe));

  a_r11_data_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (trdy_oe && !trdy_n));
endmodule

bind bus_burst_target bus_burst_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
  .devsel_n(devsel_n), .devsel_oe(devsel_oe)
);

// File: tb/bus_burst_target_tb.sv
module bus_burst_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam logic [3:0] MRD = 4'b0110, MWR = 4'b0111, CRD = 4'b1010, CWR = 4'b1011;

  logic clk = 0, rst_n = 0, frame_n = 1, irdy_n = 1, cfg_sel = 0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = '0;
  logic [31:0] ad_out;
  logic ad_oe, trdy_n, trdy_oe, devsel_n, devsel_oe;

  int tests = 0, fails = 0;
  logic [31:0] exp_rf [8];
  logic [31:0] wd [8];
  logic [3:0]  be [8];
  logic [31:0] rd [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_burst_target u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cfg_sel(cfg_sel),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n),
    .trdy_oe(trdy_oe), .devsel_n(devsel_n), .devsel_oe(devsel_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] quiet();
    return {ad_oe, trdy_oe, devsel_oe};
  endfunction

  task automatic burst(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                       input int n, input int waits, input bit hit);
    bit is_wr = cmd[0];
    int cyc = 0;
    int start = addr[4:2];
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; cfg_sel = sel;
    @(negedge clk);
    cfg_sel = 0;
    for (int b = 0; b < n; b++) begin
      for (int w = 0; w < waits; w++) begin
        irdy_n = 1; frame_n = 0; cbe_n = be[b]; ad_in = is_wr ? wd[b] : '0;
        #1;
        if (cyc == 0)
          chk(hit ? (devsel_oe && !devsel_n) : (quiet() == 0), "R5 select after address phase", {31'd0, devsel_oe}, {31'd0, hit});
        @(negedge clk); cyc++;
      end
      irdy_n = 0; frame_n = (b == n-1); cbe_n = be[b]; ad_in = is_wr ? wd[b] : '0;
      #1;
      if (cyc == 0)
        chk(hit ? (devsel_oe && !devsel_n) : (quiet() == 0), "R5 select after address phase", {31'd0, devsel_oe}, {31'd0, hit});
      if (!hit) begin
        chk(quiet() == 0, "R4 miss drives nothing", {29'd0, quiet()}, 32'd0);
        @(negedge clk); cyc++;
        continue;
      end
      for (int g = 0; g < 20 && trdy_n; g++) begin
        @(negedge clk); #1; cyc++;
      end
      if (b == 0)
        chk(cyc == ((!is_wr && waits < 1) ? 1 : waits), "R6 first ready latency", cyc, (!is_wr && waits < 1) ? 1 : waits);
      if (!is_wr) begin
        rd[b] = ad_out;
        chk(ad_oe && !trdy_n, "R11 read data driven with ready", {31'd0, ad_oe}, 32'd1);
      end else begin
        chk(!ad_oe && !trdy_n, "R11 no drive on write", {31'd0, ad_oe}, 32'd0);
        for (int k = 0; k < 4; k++)
          if (!be[b][k]) exp_rf[(start + b) % 8][8*k +: 8] = wd[b][8*k +: 8];
      end
      @(negedge clk); cyc++;
    end
    frame_n = 1; irdy_n = 1; ad_in = '0; cbe_n = '0;
    #1;
    chk(quiet() == 0 && trdy_n && devsel_n, "R10 released after last phase", {29'd0, quiet()}, 32'd0);
  endtask

  task automatic read_check(input logic [31:0] addr, input int n, input int waits, input string req);
    int start = addr[4:2];
    burst(MRD, addr, 0, n, waits, 1);
    for (int b = 0; b < n; b++)
      chk(rd[b] === exp_rf[(start + b) % 8], req, rd[b], exp_rf[(start + b) % 8]);
  endtask

  task automatic t_reset();
    #3;
    chk(quiet() == 0 && trdy_n && devsel_n && ad_out == 0, "R1 outputs released in reset", {29'd0, quiet()}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) exp_rf[i] = '0;
    for (int i = 0; i < 8; i++) be[i] = 4'h0;
    read_check(BASE, 8, 0, "R1 file cleared by reset");
  endtask

  task automatic t_write_burst();
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h1111_0000 * (i + 1) + i; be[i] = 4'h0; end
    burst(MWR, BASE, 0, 4, 0, 1);
    read_check(BASE, 4, 0, "R2 R9 burst write then read");
  endtask

  task automatic t_byte_enables();
    wd[0] = 32'hAABB_CCDD; be[0] = 4'b1010;
    burst(MWR, BASE + 32'h14, 0, 1, 0, 1);
    wd[0] = 32'h1234_5678; be[0] = 4'b0101;
    burst(MWR, BASE + 32'h0C, 0, 1, 0, 1);
    be[0] = 4'h0;
    read_check(BASE + 32'h14, 1, 0, "R8 enables bytes 0 and 2");
    read_check(BASE + 32'h0C, 1, 0, "R8 enables bytes 1 and 3");
  endtask

  task automatic t_initiator_waits();
    for (int i = 0; i < 3; i++) begin wd[i] = 32'hC0DE_0000 + i; be[i] = 4'h0; end
    burst(MWR, BASE + 32'h08, 0, 3, 2, 1);
    read_check(BASE + 32'h08, 3, 1, "R7 stalled read burst");
    read_check(BASE + 32'h08, 3, 3, "R7 long stalls");
  endtask

  task automatic t_config();
    wd[0] = 32'hCAFE_F00D; be[0] = 4'h0;
    burst(CWR, 32'h0000_0018, 1, 1, 0, 1);
    be[0] = 4'h0;
    read_check(BASE + 32'h18, 1, 0, "R3 config write seen by memory read");
    wd[0] = 32'hDEAD_DEAD;
    burst(CWR, 32'h0000_0018, 0, 1, 0, 0);
    read_check(BASE + 32'h18, 1, 0, "R3 config without select ignored");
    burst(CRD, 32'h0000_0018, 1, 1, 0, 1);
    chk(rd[0] === exp_rf[6], "R3 config read", rd[0], exp_rf[6]);
  endtask

  task automatic t_miss();
    for (int i = 0; i < 2; i++) begin wd[i] = 32'hBAD0_0000 + i; be[i] = 4'h0; end
    burst(MWR, BASE + 32'h8000, 0, 2, 0, 0);
    burst(MRD, BASE - 32'h20, 0, 2, 1, 0);
    read_check(BASE, 8, 0, "R4 out of window leaves file");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 3; i++) begin wd[i] = 32'h7777_0000 + i; be[i] = 4'h0; end
    burst(MWR, BASE + 32'h1C, 0, 3, 0, 1);
    read_check(BASE + 32'h1C, 4, 0, "R9 index wraps");
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    frame_n = 0; ad_in = BASE; cbe_n = MRD;
    @(negedge clk);
    irdy_n = 0; cbe_n = 4'h0;
    @(negedge clk);
    #1;
    chk(ad_oe && !trdy_n, "R11 read active before reset", {31'd0, ad_oe}, 32'd1);
    #1 rst_n = 0;
    #1;
    chk(quiet() == 0 && trdy_n && devsel_n, "R1 async release mid burst", {29'd0, quiet()}, 32'd0);
    @(negedge clk);
    frame_n = 1; irdy_n = 1; ad_in = '0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) exp_rf[i] = '0;
    read_check(BASE, 8, 0, "R1 file cleared after async reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_write_burst();
    t_byte_enables();
    t_initiator_waits();
    t_config();
    t_miss();
    t_wrap();
    t_async_reset();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule